// File: doc/BRIEF.md
# Burst Code Fetch Sequencer

This block runs the code-read side of a multiplexed external memory bus for a processor core that fetches instructions ahead of execution. Each fetch is either a long cycle, in which an address-latch pulse carries the full address before the read strobe, or a short burst cycle, in which only the read strobe is given and the low address bits have moved on. The long cycle is spent only when the latched upper address may have changed: after reset, on a redirect, on a vector request, or when sequential fetching steps into a new aligned 16-byte block.

Fetched bytes go into a small byte queue that the core drains one byte at a time. The sequencer keeps fetching for as long as the queue has room for one more bus unit, so it may read code that is never executed. A redirect or vector request empties the queue and aborts any fetch in progress, and the data of that fetch is dropped. A vector request first reads a 16-bit handler address from the vector location, then starts fetching code at that handler address with a fresh address-latch cycle.

The bus width is chosen by `bus_wide_i`. It may change only in the same cycle that a redirect or vector request is presented. `RESET_ADDR` must be even.

Top module: `burst_fetch_seq`

## Requirements
- R1: While reset is held, `ale_o` is 0, `psen_n_o` is 1 and `q_valid_o` is 0. The first bus cycle after reset is an address-latch cycle at `RESET_ADDR`.
- R2: An address-latch cycle holds `ale_o` high for one clock with the full address on `addr_o`. Unless a request aborts it, the next clock has `psen_n_o` low with the same address. `ale_o` and a low `psen_n_o` never occur in the same clock.
- R3: A sequential fetch that stays inside the same aligned 16-byte block is a burst. `psen_n_o` goes low with no `ale_o`, the address is one bus unit above the previous fetch, and `addr_o[AW-1:4]` is unchanged.
- R4: A sequential fetch whose address has `addr_o[3:0]` equal to zero always begins with an address-latch cycle.
- R5: With `bus_wide_i` = 1 (16-bit bus), every address driven has bit 0 at 0 and fetches advance by 2. Each fetch places `mem_rdata_i[7:0]` (even byte) and then `mem_rdata_i[15:8]` (odd byte) into the queue. With `bus_wide_i` = 0, fetches advance by 1 and only `mem_rdata_i[7:0]` is used.
- R6: A redirect (`redir_req_i` high for one clock) is followed in the next clock by an address-latch cycle at the target, with bit 0 cleared in 16-bit mode. This holds even when the target lies in the block already latched.
- R7: A redirect or vector request empties the queue in the next clock. Any fetch in flight is aborted, and none of its data reaches the queue.
- R8: A vector request is followed by an address-latch cycle and a strobe at `vec_addr_i`. That read places nothing in the queue. All of `mem_rdata_i[AW-1:0]` is taken as the handler address, and a second address-latch cycle at that address follows directly.
- R9: When a vector request and a redirect arrive in the same clock, the vector request is served and the redirect is dropped.
- R10: No fetch starts while the queue lacks room for one bus unit. Fetching resumes once the core pops enough bytes.
- R11: Bytes leave the queue on `q_data_o` in ascending code address order, starting at the latest redirect target, handler address or reset address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wide_i | input | 1 | 1: 16-bit bus, 0: 8-bit bus |
| redir_req_i | input | 1 | Branch redirect request, one clock |
| redir_addr_i | input | AW | Redirect target byte address |
| vec_req_i | input | 1 | Interrupt/exception vector request, one clock |
| vec_addr_i | input | AW | Address of the vector entry |
| mem_rdata_i | input | 16 | Read data from code memory |
| q_pop_i | input | 1 | Core takes the byte on `q_data_o` |
| ale_o | output | 1 | Address-latch enable |
| psen_n_o | output | 1 | Active-low code read strobe |
| addr_o | output | AW | Code address lines |
| q_valid_o | output | 1 | Queue holds at least one byte |
| q_data_o | output | 8 | Oldest queued byte |

## Verification
The bench watches every bus cycle. It fails any strobe that bursts across a 16-byte boundary, any latch cycle that has no reason behind it, and any burst that skips or repeats an address. Together these catch a boundary test that looks at the wrong bits, as well as a width-dependent step that is wrong. Redirects are timed to land on a live strobe, on a live latch cycle, and on a target inside the current block. A design that lets aborted data through, or that skips the latch cycle when the upper address happens to match, then either puts stray bytes in front of the scoreboard or misses an expected latch cycle. Vector requests are issued alone, together with a redirect, and with a handler whose first bytes run into the next block. This exposes a design that queues the vector word, lets the redirect win, or leaves out the third latch cycle. Holding the consumer back shows whether fetching stops on a full queue and starts again afterwards.

// File: rtl/bfs_pkg.sv
package bfs_pkg;
  // Width of the low address field that may change inside a burst.
  localparam int BLK_W = 4;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_ALE  = 2'd1,
    FS_STRB = 2'd2
  } fstate_e;
endpackage

// File: rtl/bfs_rst_sync.sv
module bfs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/bfs_pfq.sv
module bfs_pfq #(
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          push_two_i,
  input  logic [15:0]   wdata_i,
  input  logic          pop_i,
  input  logic          flush_i,
  output logic          rvalid_o,
  output logic [7:0]    rdata_o,
  output logic [CW-1:0] free_next_o
);
  localparam int PW = $clog2(DEPTH);

  logic [PW-1:0] wr_q, wr_d;
  logic [PW-1:0] rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] n_in;
  logic          pop_fire;
  logic [DEPTH-1:0][7:0] slot_w;

  assign pop_fire = pop_i && (cnt_q != '0);
  assign n_in     = push_i ? (push_two_i ? CW'(2) : CW'(1)) : '0;

  always_comb begin
    if (flush_i) begin
      cnt_d = '0;
      wr_d  = '0;
      rd_d  = '0;
    end else begin
      cnt_d = cnt_q + n_in - CW'(pop_fire);
      wr_d  = wr_q + PW'(n_in);
      rd_d  = rd_q + PW'(pop_fire);
    end
  end

  assign free_next_o = CW'(DEPTH) - cnt_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      wr_q  <= '0;
      rd_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      wr_q  <= wr_d;
      rd_q  <= rd_d;
    end
  end

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    logic       we_lo;
    logic       we_hi;
    logic [7:0] byte_q;

    assign we_lo = push_i && (wr_q == PW'(gi));
    assign we_hi = push_i && push_two_i && ((wr_q + PW'(1)) == PW'(gi));

    always_ff @(posedge clk) begin
      if (we_lo) begin
        byte_q <= wdata_i[7:0];
      end else if (we_hi) begin
        byte_q <= wdata_i[15:8];
      end
    end

    assign slot_w[gi] = byte_q;
  end

  assign rvalid_o = (cnt_q != '0);
  assign rdata_o  = slot_w[rd_q];
endmodule

// File: rtl/bfs_fetch_ctl.sv
module bfs_fetch_ctl
  import bfs_pkg::*;
#(
  parameter int          AW         = 16,
  parameter int          CW         = 4,
  parameter logic [AW-1:0] RESET_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wide_i,
  input  logic          redir_req_i,
  input  logic [AW-1:0] redir_addr_i,
  input  logic          vec_req_i,
  input  logic [AW-1:0] vec_addr_i,
  input  logic [15:0]   rdata_i,
  input  logic [CW-1:0] free_next_i,
  output logic          ale_o,
  output logic          psen_n_o,
  output logic [AW-1:0] addr_o,
  output logic          push_o,
  output logic          push_two_o,
  output logic          flush_o
);
  fstate_e       state_q, state_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic          need_ale_q, need_ale_d;
  logic          vec_q, vec_d;
  logic          launch;
  logic [AW-1:0] step;
  logic [CW-1:0] unit_bytes;

  function automatic logic [AW-1:0] align_f(input logic [AW-1:0] a, input logic w);
    return w ? {a[AW-1:1], 1'b0} : a;
  endfunction

  assign step       = wide_i ? AW'(2) : AW'(1);
  assign unit_bytes = wide_i ? CW'(2) : CW'(1);
  assign flush_o    = vec_req_i || redir_req_i;

  // Next-state logic
  always_comb begin
    state_d    = state_q;
    ptr_d      = ptr_q;
    need_ale_d = need_ale_q;
    vec_d      = vec_q;
    launch     = 1'b0;
    if (vec_req_i) begin
      ptr_d      = align_f(vec_addr_i, wide_i);
      need_ale_d = 1'b1;
      vec_d      = 1'b1;
      state_d    = FS_ALE;
    end else if (redir_req_i) begin
      ptr_d      = align_f(redir_addr_i, wide_i);
      need_ale_d = 1'b1;
      vec_d      = 1'b0;
      state_d    = FS_ALE;
    end else begin
      case (state_q)
        FS_ALE: state_d = FS_STRB;
        FS_STRB: begin
          if (vec_q) begin
            ptr_d      = align_f(AW'(rdata_i), wide_i);
            need_ale_d = 1'b1;
            vec_d      = 1'b0;
          end else begin
            ptr_d      = ptr_q + step;
            need_ale_d = (ptr_d[BLK_W-1:0] == '0);
          end
          launch = 1'b1;
        end
        default: launch = 1'b1;
      endcase
      if (launch) begin
        if (free_next_i >= unit_bytes) begin
          state_d = need_ale_d ? FS_ALE : FS_STRB;
        end else begin
          state_d = FS_IDLE;
        end
      end
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= FS_IDLE;
      ptr_q      <= RESET_ADDR;
      need_ale_q <= 1'b1;
      vec_q      <= 1'b0;
    end else begin
      state_q    <= state_d;
      ptr_q      <= ptr_d;
      need_ale_q <= need_ale_d;
      vec_q      <= vec_d;
    end
  end

  assign ale_o      = (state_q == FS_ALE);
  assign psen_n_o   = (state_q != FS_STRB);
  assign addr_o     = ptr_q;
  assign push_o     = (state_q == FS_STRB) && !vec_q && !flush_o;
  assign push_two_o = wide_i;
endmodule

// File: rtl/burst_fetch_seq.sv
module burst_fetch_seq #(
  parameter int            AW         = 16,
  parameter int            QBYTES     = 8,
  parameter logic [AW-1:0] RESET_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wide_i,
  input  logic          redir_req_i,
  input  logic [AW-1:0] redir_addr_i,
  input  logic          vec_req_i,
  input  logic [AW-1:0] vec_addr_i,
  input  logic [15:0]   mem_rdata_i,
  input  logic          q_pop_i,
  output logic          ale_o,
  output logic          psen_n_o,
  output logic [AW-1:0] addr_o,
  output logic          q_valid_o,
  output logic [7:0]    q_data_o
);
  localparam int CW = $clog2(QBYTES + 1);

  logic          rst_sync_n;
  logic          push;
  logic          push_two;
  logic          flush;
  logic [CW-1:0] free_next;

  bfs_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bfs_fetch_ctl #(
    .AW         (AW),
    .CW         (CW),
    .RESET_ADDR (RESET_ADDR)
  ) u_ctl (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .wide_i       (bus_wide_i),
    .redir_req_i  (redir_req_i),
    .redir_addr_i (redir_addr_i),
    .vec_req_i    (vec_req_i),
    .vec_addr_i   (vec_addr_i),
    .rdata_i      (mem_rdata_i),
    .free_next_i  (free_next),
    .ale_o        (ale_o),
    .psen_n_o     (psen_n_o),
    .addr_o       (addr_o),
    .push_o       (push),
    .push_two_o   (push_two),
    .flush_o      (flush)
  );

  bfs_pfq #(
    .DEPTH (QBYTES),
    .CW    (CW)
  ) u_pfq (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .push_i      (push),
    .push_two_i  (push_two),
    .wdata_i     (mem_rdata_i),
    .pop_i       (q_pop_i),
    .flush_i     (flush),
    .rvalid_o    (q_valid_o),
    .rdata_o     (q_data_o),
    .free_next_o (free_next)
  );
endmodule

// File: rtl/burst_fetch_seq_chk.sv
module burst_fetch_seq_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wide_i,
  input logic          redir_req_i,
  input logic [AW-1:0] redir_addr_i,
  input logic          vec_req_i,
  input logic [AW-1:0] vec_addr_i,
  input logic          ale_o,
  input logic          psen_n_o,
  input logic [AW-1:0] addr_o,
  input logic          q_valid_o
);
  logic quiet;
  assign quiet = !redir_req_i && !vec_req_i;

  AST_ALE_PSEN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ale_o && !psen_n_o)); // R2

  AST_ALE_THEN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (ale_o && quiet) |=> (!psen_n_o && addr_o == $past(addr_o))); // R2

  AST_BURST_IN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (!psen_n_o && quiet) |=> (psen_n_o || addr_o[AW-1:4] == $past(addr_o[AW-1:4]))); // R3

  AST_BOUNDARY_NEEDS_ALE: assert property (@(posedge clk) disable iff (!rst_n)
    (!psen_n_o && quiet) |=> !(!psen_n_o && addr_o[3:0] == 4'h0)); // R4

  AST_WIDE_NO_A0: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wide_i && quiet && (ale_o || !psen_n_o)) |-> !addr_o[0]); // R5

  AST_REDIRECT_ALE: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_req_i && !vec_req_i) |=>
      (ale_o && addr_o == $past({redir_addr_i[AW-1:1], redir_addr_i[0] & !bus_wide_i}))); // R6

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_req_i || vec_req_i) |=> !q_valid_o); // R7

  AST_VEC_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req_i |=>
      (ale_o && addr_o == $past({vec_addr_i[AW-1:1], vec_addr_i[0] & !bus_wide_i}))); // R9
endmodule

bind burst_fetch_seq burst_fetch_seq_chk #(.AW(AW)) chk_i (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .bus_wide_i   (bus_wide_i),
  .redir_req_i  (redir_req_i),
  .redir_addr_i (redir_addr_i),
  .vec_req_i    (vec_req_i),
  .vec_addr_i   (vec_addr_i),
  .ale_o        (ale_o),
  .psen_n_o     (psen_n_o),
  .addr_o       (addr_o),
  .q_valid_o    (q_valid_o)
);

// File: tb/burst_fetch_seq_tb_top.sv
module burst_fetch_seq_tb_top;
  timeunit 1ns;
  timeprecision 100ps;

  localparam logic [15:0] RST_A   = 16'h0000;
  localparam logic [15:0] VEC_A   = 16'hFF00;
  localparam logic [15:0] HANDLER = 16'h123C;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wide;
  logic        redir_req;
  logic [15:0] redir_addr;
  logic        vec_req;
  logic [15:0] vec_addr;
  logic [15:0] mem_rdata;
  logic        q_pop;
  logic        ale, psen_n, q_valid;
  logic [15:0] addr;
  logic [7:0]  q_data;

  always #2.5 clk = ~clk;

  burst_fetch_seq #(.AW(16), .QBYTES(8), .RESET_ADDR(RST_A)) dut_i (
    .clk (clk), .rst_n (rst_n), .bus_wide_i (bus_wide),
    .redir_req_i (redir_req), .redir_addr_i (redir_addr),
    .vec_req_i (vec_req), .vec_addr_i (vec_addr),
    .mem_rdata_i (mem_rdata), .q_pop_i (q_pop),
    .ale_o (ale), .psen_n_o (psen_n), .addr_o (addr),
    .q_valid_o (q_valid), .q_data_o (q_data)
  );

  function automatic logic [7:0] fb(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
  endfunction

  function automatic logic [15:0] al(input logic [15:0] a, input logic w);
    return w ? {a[15:1], 1'b0} : a;
  endfunction

  // Code memory model
  always_comb begin
    if ({addr[15:1], 1'b0} == VEC_A)      mem_rdata = HANDLER;
    else if (bus_wide)                    mem_rdata = {fb(addr | 16'h1), fb({addr[15:1], 1'b0})};
    else                                  mem_rdata = {~fb(addr), fb(addr)};
  end

  int n_checks = 0;
  int n_fail   = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Scoreboard and monitor state
  logic [7:0]  sb[$];
  bit          hold;
  bit          mode_w;
  bit          have_last;
  logic [15:0] last_addr;
  bit          prev_ale, prev_req;
  logic [15:0] prev_ale_addr;
  bit          exp_ale_valid;
  logic [15:0] exp_ale_addr;
  string       exp_tag;
  bit          vec_rd;
  int          strobes_done;

  task automatic push_expected(input logic [15:0] start, input int n);
    for (int i = 0; i < n; i++) sb.push_back(fb(start + 16'(i)));
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_ale = 1'b0;
      prev_req = 1'b0;
      q_pop    = 1'b0;
    end else begin
      automatic bit          req_now = redir_req || vec_req;
      automatic logic [15:0] unit    = mode_w ? 16'd2 : 16'd1;
      automatic logic [7:0]  e;
      if (ale && !psen_n) check(1'b0, "R2", {ale, psen_n}, 2'b10);
      if (prev_ale && !prev_req)
        check(!psen_n && addr == prev_ale_addr, "R2", {psen_n, addr}, {1'b0, prev_ale_addr});
      if (ale && !req_now) begin
        if (exp_ale_valid) begin
          check(addr == exp_ale_addr, exp_tag, addr, exp_ale_addr);
          exp_ale_valid = 1'b0;
        end else begin
          check(have_last && addr == last_addr + unit && addr[3:0] == 4'h0, "R4", addr, last_addr + unit);
        end
      end
      if (!psen_n && !req_now) begin
        if (!prev_ale)
          check(!exp_ale_valid && have_last && addr == last_addr + unit && addr[3:0] != 4'h0,
                "R3", addr, last_addr + unit);
        if (mode_w) check(!addr[0], "R5", addr, {addr[15:1], 1'b0});
        if (vec_rd) begin
          check(addr == VEC_A, "R8", addr, VEC_A);
          vec_rd        = 1'b0;
          exp_ale_addr  = al(HANDLER, mode_w);
          exp_tag       = "R8";
          exp_ale_valid = 1'b1;
          have_last     = 1'b0;
        end else begin
          last_addr = addr;
          have_last = 1'b1;
          strobes_done++;
        end
      end
      prev_ale      = ale;
      prev_ale_addr = addr;
      prev_req      = req_now;
      q_pop = 1'b0;
      if (!hold && q_valid && sb.size() > 0) begin
        e = sb.pop_front();
        check(q_data == e, "R11", q_data, e);
        q_pop = 1'b1;
      end
    end
  end

  // Driver: one request, with optional alignment to a live strobe or latch cycle
  task automatic issue(input bit do_vec, input bit do_redir, input logic [15:0] tgt,
                       input bit new_w, input string tag, input int nbytes,
                       input bit at_strobe, input bit at_ale);
    @(posedge clk); #1;
    if (at_strobe) while (psen_n) begin @(posedge clk); #1; end
    if (at_ale)    while (!ale)   begin @(posedge clk); #1; end
    hold          = 1'b1;
    bus_wide      = new_w;
    redir_req     = do_redir;
    redir_addr    = tgt;
    vec_req       = do_vec;
    vec_addr      = VEC_A;
    exp_ale_valid = 1'b1;
    exp_tag       = tag;
    exp_ale_addr  = do_vec ? VEC_A : al(tgt, new_w);
    vec_rd        = do_vec;
    @(posedge clk); #1;
    redir_req = 1'b0;
    vec_req   = 1'b0;
    mode_w    = new_w;
    have_last = 1'b0;
    check(!q_valid, "R7", q_valid, 1'b0);
    sb.delete();
    push_expected(do_vec ? al(HANDLER, new_w) : al(tgt, new_w), nbytes);
    hold = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int s1;
    rst_n = 1'b0; bus_wide = 1'b0; redir_req = 1'b0; vec_req = 1'b0;
    redir_addr = '0; vec_addr = VEC_A; hold = 1'b0; mode_w = 1'b0;
    have_last = 1'b0; vec_rd = 1'b0; strobes_done = 0; q_pop = 1'b0;
    exp_ale_valid = 1'b1; exp_ale_addr = RST_A; exp_tag = "R1";
    push_expected(RST_A, 200);
    repeat (4) @(posedge clk); #1;
    check(!ale && psen_n && !q_valid, "R1", {ale, psen_n, q_valid}, 3'b010);
    rst_n = 1'b1;
    repeat (60) @(posedge clk);

    // Redirect landing on a live strobe (abort), then inside the current block
    issue(1'b0, 1'b1, 16'h0107, 1'b0, "R6", 200, 1'b1, 1'b0);
    repeat (40) @(posedge clk);
    issue(1'b0, 1'b1, {last_addr[15:4], 4'h9}, 1'b0, "R6", 200, 1'b0, 1'b0);
    repeat (40) @(posedge clk);
    issue(1'b0, 1'b1, 16'h0350, 1'b0, "R6", 200, 1'b0, 1'b1);
    repeat (30) @(posedge clk);

    // Full queue stalls fetching
    hold = 1'b1;
    repeat (40) @(posedge clk); #1;
    s1 = strobes_done;
    check(q_valid, "R10", q_valid, 1'b1);
    repeat (20) @(posedge clk); #1;
    check(strobes_done == s1, "R10", strobes_done, s1);
    hold = 1'b0;
    repeat (20) @(posedge clk); #1;
    check(strobes_done > s1, "R10", strobes_done, s1 + 1);

    // 16-bit bus, odd target aligned down
    issue(1'b0, 1'b1, 16'h0231, 1'b1, "R5", 200, 1'b1, 1'b0);
    repeat (60) @(posedge clk);
    // Vector in 16-bit mode, then vector and redirect together
    issue(1'b1, 1'b0, 16'h0000, 1'b1, "R8", 200, 1'b0, 1'b0);
    repeat (40) @(posedge clk);
    issue(1'b1, 1'b1, 16'h0500, 1'b1, "R9", 200, 1'b0, 1'b0);
    repeat (40) @(posedge clk);
    // Vector in 8-bit mode: handler runs into the next block (third latch)
    issue(1'b1, 1'b0, 16'h0000, 1'b0, "R8", 200, 1'b1, 1'b0);
    repeat (40) @(posedge clk);
    hold = 1'b1;
    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule